// File: doc/BRIEF.md
# Register-Programmed PWM Timer Channel

This block is one pulse-width-modulation channel driven by a simple register port with two 32-bit words. The first word is a control word. The second word holds the period length and the high-phase length. The input clock goes through a power-of-two prescaler. Each prescaled tick advances a period counter. The output is high from the start of each period until the phase count is reached, and low for the rest of the period.

Software uses a hold bit to change settings without a glitch. While the hold bit is set, new counts and clock settings stay in shadow storage. After the bit is cleared, all of them move into the running configuration together at the next period boundary.

The channel refuses to run while either count is zero, so 0% duty cannot be produced. A single-shot option runs one period and then clears the enable bit.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset both registers read zero, `pwm_o` is low and `active_o` is low.
- R2: Control word at byte offset 0x0: bit 0 enable, bit 4 single-shot, bit 11 hold, bit 15 exponent LSB, bits 19:16 exponent upper bits. Count word at offset 0x4: bits 25:16 period count, bits 9:0 phase count. Every other bit reads zero, and reads return the last written values.
- R3: A control write that sets enable while the stored period or phase count is zero is refused. The enable bit reads 0, and `active_o` and `pwm_o` stay low.
- R4: Call the exponent N = {bits 19:16, bit 15}. Count k clock cycles from the first cycle after a successful enable. Then `pwm_o` = ((k >> N) mod period) < phase, and `active_o` is high.
- R5: If the phase count is at least the period count, `pwm_o` stays high for the whole period.
- R6: A control write with enable 0 makes `pwm_o` and `active_o` low in the next cycle.
- R7: While the hold bit is 1, writes to the counts and exponent do not change the output. After hold is cleared, the new values apply together at the first period boundary after the clearing write.
- R8: With single-shot set, exactly one period is produced. Then `active_o` and `pwm_o` go low and the enable bit reads 0.
- R9: A count write without hold while running takes effect at the next period boundary, not mid-period.
- R10: Writes to any other offset are ignored, and reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_o | output | 1 | PWM output, normal polarity |
| active_o | output | 1 | Channel running |

## Verification
The bench builds the block with its default parameters: 10-bit counts, a 4-bit exponent field, a maximum exponent of 24 and a 3-bit address. Random runs use exponents 0 to 3, periods 1 to 20 and phases 1 to 24. This covers phases both below and above the period, and full periods fit in a short run. Directed sequences time the hold release and the unstaged mid-period update against the period boundary. They also cover the single-shot stop, the refused enable with each zero field, and field readback with all bits written.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

   // byte offsets of the two words
   localparam int unsigned CTRL_OFF  = 0;
   localparam int unsigned CNT_OFF   = 4;

   // control word fields
   localparam int unsigned EN_BIT    = 0;
   localparam int unsigned ONE_BIT   = 4;
   localparam int unsigned HOLD_BIT  = 11;
   localparam int unsigned XLSB_BIT  = 15;
   localparam int unsigned XHI_LSB   = 16;

   // count word fields
   localparam int unsigned PER_LSB   = 16;
   localparam int unsigned PH_LSB    = 0;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_CNT  = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_chan_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int CC_W    = 4,
   parameter int MAX_EXP = 24,
   parameter int ADDR_W  = 3,
   parameter int EXP_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   input  logic              boundary_i,
   input  logic              running_i,
   output logic              en_o,
   output logic [CNT_W-1:0]  per_o,
   output logic [CNT_W-1:0]  ph_o,
   output logic [EXP_W-1:0]  exp_o
);

   localparam int RAW_W = CC_W + 1;
   localparam logic [RAW_W-1:0] MAX_RAW = RAW_W'(MAX_EXP);

   reg_sel_e          sel;
   logic              wr_ctrl, wr_cnt;
   logic              en_q, one_q, hold_q, pend_q;
   logic              sh_xlsb;
   logic [CC_W-1:0]   sh_xhi;
   logic [CNT_W-1:0]  sh_per, sh_ph;
   logic [RAW_W-1:0]  sh_raw;
   logic [EXP_W-1:0]  sh_exp;
   logic              counts_ok;
   logic              load;
   logic              unused_wdata;

   assign unused_wdata = ^wdata_i;

   always_comb begin
      sel = SEL_NONE;
      if (addr_i == ADDR_W'(CTRL_OFF))     sel = SEL_CTRL;
      else if (addr_i == ADDR_W'(CNT_OFF)) sel = SEL_CNT;
   end

   assign wr_ctrl = wr_i && (sel == SEL_CTRL);
   assign wr_cnt  = wr_i && (sel == SEL_CNT);

   // exponent from split field, saturated at the largest supported value
   assign sh_raw = {sh_xhi, sh_xlsb};
   always_comb begin
      if (sh_raw > MAX_RAW) sh_exp = EXP_W'(MAX_EXP);
      else                  sh_exp = EXP_W'(sh_raw);
   end

   assign counts_ok = (sh_per != '0) && (sh_ph != '0);
   assign load      = pend_q && !hold_q && (!running_i || boundary_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         one_q   <= 1'b0;
         hold_q  <= 1'b0;
         pend_q  <= 1'b0;
         sh_xlsb <= 1'b0;
         sh_xhi  <= '0;
         sh_per  <= '0;
         sh_ph   <= '0;
         per_o   <= '0;
         ph_o    <= '0;
         exp_o   <= '0;
      end else begin
         if (wr_cnt) begin
            sh_per <= wdata_i[PER_LSB +: CNT_W];
            sh_ph  <= wdata_i[PH_LSB +: CNT_W];
         end
         if (wr_ctrl) begin
            en_q    <= wdata_i[EN_BIT] && counts_ok;
            one_q   <= wdata_i[ONE_BIT];
            hold_q  <= wdata_i[HOLD_BIT];
            sh_xlsb <= wdata_i[XLSB_BIT];
            sh_xhi  <= wdata_i[XHI_LSB +: CC_W];
         end else if (boundary_i && one_q) begin
            en_q <= 1'b0;
         end
         if (wr_cnt || wr_ctrl) pend_q <= 1'b1;
         else if (load)         pend_q <= 1'b0;
         if (load) begin
            per_o <= sh_per;
            ph_o  <= sh_ph;
            exp_o <= sh_exp;
         end
      end
   end

   assign en_o = en_q;

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_CTRL: begin
            rdata_o[EN_BIT]             = en_q;
            rdata_o[ONE_BIT]            = one_q;
            rdata_o[HOLD_BIT]           = hold_q;
            rdata_o[XLSB_BIT]           = sh_xlsb;
            rdata_o[XHI_LSB +: CC_W]    = sh_xhi;
         end
         SEL_CNT: begin
            rdata_o[PER_LSB +: CNT_W]   = sh_per;
            rdata_o[PH_LSB +: CNT_W]    = sh_ph;
         end
         default: ;
      endcase
   end

   // R7
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |=> ($stable(per_o) && $stable(ph_o) && $stable(exp_o)));

   // R9
   mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running_i && !boundary_i) |=> ($stable(per_o) && $stable(ph_o) && $stable(exp_o)));

   // R8
   single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && one_q && !wr_ctrl) |=> !en_o);

endmodule

// File: rtl/pwm_chan_prescale.sv
module pwm_chan_prescale #(
   parameter int MAX_EXP = 24,
   parameter int EXP_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             tick_o
);

   localparam int PW = (MAX_EXP < 1) ? 1 : MAX_EXP;

   generate
      if (MAX_EXP == 0) begin : g_nodiv
         logic unused_exp;
         assign unused_exp = ^exp_i;
         assign tick_o = running_i;
      end else begin : g_div
         logic [PW-1:0] presc_q;
         logic [PW-1:0] mask;

         assign mask   = ~({PW{1'b1}} << exp_i);
         assign tick_o = running_i && (presc_q == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   presc_q <= '0;
            else if (!running_i || tick_o) presc_q <= '0;
            else                          presc_q <= presc_q + PW'(1);
         end

         // R4
         presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            running_i |-> (presc_q <= mask));
      end
   endgenerate

endmodule

// File: rtl/pwm_chan_period.sv
module pwm_chan_period #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] ph_i,
   output logic             boundary_o,
   output logic             pwm_o
);

   logic [CNT_W-1:0] pcnt_q;
   logic             last;

   assign last       = (pcnt_q == per_i - CNT_W'(1));
   assign boundary_o = running_i && tick_i && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pcnt_q <= '0;
      else if (!running_i) pcnt_q <= '0;
      else if (tick_i)     pcnt_q <= last ? '0 : pcnt_q + CNT_W'(1);
   end

   assign pwm_o = running_i && (pcnt_q < ph_i);

   // R4
   pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running_i |-> (pcnt_q < per_i));

   // R4
   no_zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running_i && pcnt_q == '0) |-> pwm_o);

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
   import pwm_chan_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int CC_W    = 4,
   parameter int MAX_EXP = 24,
   parameter int ADDR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              pwm_o,
   output logic              active_o
);

   localparam int EXP_W = (MAX_EXP < 1) ? 1 : $clog2(MAX_EXP + 1);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 2..16");
      end
      if (CC_W < 1 || CC_W > 15) begin : g_bad_cc
         $error("CC_W must lie in 1..15");
      end
      if (MAX_EXP < 0 || MAX_EXP > (2 ** (CC_W + 1)) - 1) begin : g_bad_exp
         $error("MAX_EXP must be encodable in the exponent fields");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach offset 4");
      end
   endgenerate

   logic             en;
   logic [CNT_W-1:0] act_per, act_ph;
   logic [EXP_W-1:0] act_exp;
   logic             running, tick, boundary;

   assign running  = en && (act_per != '0) && (act_ph != '0);
   assign active_o = running;

   pwm_chan_regs #(
      .CNT_W(CNT_W), .CC_W(CC_W), .MAX_EXP(MAX_EXP), .ADDR_W(ADDR_W), .EXP_W(EXP_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
      .boundary_i(boundary), .running_i(running),
      .en_o(en), .per_o(act_per), .ph_o(act_ph), .exp_o(act_exp)
   );

   pwm_chan_prescale #(
      .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)
   ) u_presc (
      .clk(clk), .rst_n(rst_n), .running_i(running), .exp_i(act_exp), .tick_o(tick)
   );

   pwm_chan_period #(
      .CNT_W(CNT_W)
   ) u_period (
      .clk(clk), .rst_n(rst_n), .running_i(running), .tick_i(tick),
      .per_i(act_per), .ph_i(act_ph), .boundary_o(boundary), .pwm_o(pwm_o)
   );

   // R6
   disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(CTRL_OFF) && !reg_wdata[EN_BIT]) |=> (!active_o && !pwm_o));

endmodule

// File: tb/sim_pwm_timer_chan.sv
module sim_pwm_timer_chan;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        pwm_o;
   logic        active_o;

   always #5 clk = ~clk;

   pwm_timer_chan u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o), .active_o(active_o)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // segment A from base_cyc, segment B from sw_cyc
   int a_n, a_per, a_ph, b_n, b_per, b_ph, base_cyc, sw_cyc;

   function automatic logic model(int k, int n, int per, int ph);
      return ((k >> n) % per) < ph;
   endfunction

   function automatic logic exp_pwm(int c);
      if (c >= sw_cyc) return model(c - sw_cyc, b_n, b_per, b_ph);
      return model(c - base_cyc, a_n, a_per, a_ph);
   endfunction

   function automatic logic [31:0] ctrl_word(bit en, bit one, bit hold, int n);
      logic [31:0] w = '0;
      w[0] = en; w[4] = one; w[11] = hold; w[15] = n[0]; w[19:16] = n[4:1];
      return w;
   endfunction

   function automatic logic [31:0] cnt_word(int per, int ph);
      return {6'b0, per[9:0], 6'b0, ph[9:0]};
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic bus_wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic start(int n, int per, int ph, bit one);
      bus_wr(3'h0, ctrl_word(0, 0, 0, n));
      bus_wr(3'h4, cnt_word(per, ph));
      bus_wr(3'h0, ctrl_word(1, one, 0, n));
      base_cyc = cyc;
      a_n = n; a_per = per; a_ph = ph;
      sw_cyc = 32'h7fff_ffff;
   endtask

   task automatic run_window(int n, string req);
      int errs = 0;
      logic fa = 0, fe = 0;
      for (int i = 0; i < n; i++) begin
         logic e;
         e = exp_pwm(cyc);
         if (pwm_o !== e || active_o !== 1'b1) begin
            if (errs == 0) begin fa = pwm_o; fe = e; end
            errs++;
         end
         @(negedge clk);
      end
      check(errs == 0, req, "pwm waveform", fa, fe);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'd4711));
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_rd(3'h0, rd); check(rd == 0, "R1", "ctrl after reset", rd, 0);
      bus_rd(3'h4, rd); check(rd == 0, "R1", "count after reset", rd, 0);
      check(pwm_o == 0 && active_o == 0, "R1", "outputs after reset", {pwm_o, active_o}, 0);

      // R2 field positions and unused bits
      bus_wr(3'h4, 32'hFFFF_FFFF);
      bus_rd(3'h4, rd); check(rd == 32'h03FF_03FF, "R2", "count readback", rd, 32'h03FF_03FF);
      bus_wr(3'h0, 32'hFFFF_FFFE);
      bus_rd(3'h0, rd); check(rd == 32'h000F_8810, "R2", "ctrl readback", rd, 32'h000F_8810);
      bus_wr(3'h0, 32'h0);

      // R10 other offsets ignored
      bus_wr(3'h6, 32'h0);
      bus_wr(3'h2, 32'hFFFF_FFFF);
      bus_rd(3'h4, rd); check(rd == 32'h03FF_03FF, "R10", "count after stray write", rd, 32'h03FF_03FF);
      bus_rd(3'h0, rd); check(rd == 0, "R10", "ctrl after stray write", rd, 0);
      bus_rd(3'h6, rd); check(rd == 0, "R10", "read of unmapped offset", rd, 0);
      check(active_o == 0, "R10", "not running after stray write", active_o, 0);

      // R3 refused enable, zero period then zero phase
      bus_wr(3'h4, cnt_word(0, 5));
      bus_wr(3'h0, ctrl_word(1, 0, 0, 0));
      repeat (4) @(negedge clk);
      check(active_o == 0 && pwm_o == 0, "R3", "zero period outputs", {pwm_o, active_o}, 0);
      bus_rd(3'h0, rd); check(rd[0] == 0, "R3", "zero period enable bit", rd[0], 0);
      bus_wr(3'h4, cnt_word(7, 0));
      bus_wr(3'h0, ctrl_word(1, 0, 0, 0));
      repeat (4) @(negedge clk);
      check(active_o == 0 && pwm_o == 0, "R3", "zero phase outputs", {pwm_o, active_o}, 0);
      bus_rd(3'h0, rd); check(rd[0] == 0, "R3", "zero phase enable bit", rd[0], 0);

      // R4 directed
      start(0, 5, 2, 0); run_window(12, "R4");
      start(3, 3, 1, 0); run_window(50, "R4");

      // R5 then R6
      start(2, 4, 4, 0); run_window(20, "R5");
      start(1, 3, 9, 0); run_window(10, "R5");
      bus_wr(3'h0, ctrl_word(0, 0, 0, 1));
      check(pwm_o == 0 && active_o == 0, "R6", "outputs after disable", {pwm_o, active_o}, 0);
      @(negedge clk);
      check(pwm_o == 0 && active_o == 0, "R6", "outputs stay low", {pwm_o, active_o}, 0);

      // R8 single shot
      start(1, 5, 2, 1);
      begin
         int errs = 0;
         for (int k = 0; k < 16; k++) begin
            logic e, ea;
            ea = (k < 10);
            e  = ea ? model(k, 1, 5, 2) : 1'b0;
            if (pwm_o !== e || active_o !== ea) errs++;
            @(negedge clk);
         end
         check(errs == 0, "R8", "single period waveform", errs, 0);
      end
      bus_rd(3'h0, rd); check(rd[0] == 0 && rd[4] == 1, "R8", "enable self-cleared", rd, 32'h10);

      // R7 staged update under hold
      start(0, 10, 3, 0);
      run_window(13, "R7");
      bus_wr(3'h0, ctrl_word(1, 0, 1, 1));
      bus_wr(3'h4, cnt_word(6, 5));
      run_window(7, "R7");
      bus_wr(3'h0, ctrl_word(1, 0, 0, 1));
      sw_cyc = base_cyc + ((cyc - base_cyc) / 10 + 1) * 10;
      b_n = 1; b_per = 6; b_ph = 5;
      run_window(40, "R7");

      // R9 unstaged update while running
      start(1, 4, 1, 0);
      run_window(5, "R9");
      bus_wr(3'h4, cnt_word(3, 2));
      sw_cyc = base_cyc + ((cyc - base_cyc) / 8 + 1) * 8;
      b_n = 1; b_per = 3; b_ph = 2;
      run_window(30, "R9");

      // random mix: R4 and R5
      for (int r = 0; r < 24; r++) begin
         int n, per, ph;
         n   = $urandom_range(3, 0);
         per = $urandom_range(20, 1);
         ph  = $urandom_range(24, 1);
         start(n, per, ph, 0);
         run_window(2 * (per << n) + 2, (ph >= per) ? "R5" : "R4");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule